// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block keeps the transmit error count and the receive error count of a CAN controller and derives the fault-confinement state from them: error active, error passive or bus-off. The protocol engine reports each transmit error, receive error, primary receive error and successful transfer as a one-cycle strobe, and the block updates both counts on the next clock edge. A per-nominal-bit strobe, together with the sampled bus level, drives the recovery sequence out of bus-off.

Once the controller is bus-off, the receive count takes on a second job. It counts completed runs of eleven consecutive recessive bits. When the last required run completes, the controller returns to error active with both counts at zero. A soft-reset pulse, a low core-enable level and the snoop (listen-only) mode each clear both counts. A read-only 32-bit register view presents the two counts to the host.

Top module: `can_fault_conf`

## Requirements
- R1: After the synchronous reset, or one cycle after a soft-reset pulse, both counts are 0 and the state is error active (state code 0). This applies in any state, bus-off included.
- R2: While core enable is low, both counts are 0 from the following cycle and the state is error active. Error strobes have no effect during this time.
- R3: While snoop mode is high, both counts are held at 0 and error strobes have no effect. The register view reads 0 in the same cycle that snoop is high.
- R4: The register view carries the transmit count in bits 7:0 and the receive count in bits 15:8. Bits 31:16 are always 0. The register has no write path.
- R5: Outside bus-off, a transmit-error strobe adds 8 to the transmit count and a transmit-success strobe subtracts 1. The count never goes below 0, and the new value appears one cycle after the strobe.
- R6: Outside bus-off, a receive-error strobe adds 1 to the receive count, a primary receive-error strobe adds 8, and a receive-success strobe subtracts 1. The result is clamped to the range 0 to 255.
- R7: Outside bus-off, the state is error passive (code 1) when either count is 128 or more. It returns to error active (code 0) when both counts are below 128.
- R8: When a transmit update would take the transmit count above 255, the state becomes bus-off (code 2) and both counts read 0 in that same cycle.
- R9: In bus-off, all error and success strobes are ignored. The receive count rises by 1 for each run of 11 consecutive recessive bit strobes (level 1). A dominant bit strobe (level 0) restarts the run.
- R10: When the 128th run of 11 recessive bits completes during bus-off, the state returns to error active and both counts are 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_i | input | 1 | Soft-reset pulse |
| core_en_i | input | 1 | Core enable level |
| snoop_i | input | 1 | Snoop (listen-only) mode level |
| tx_err_i | input | 1 | Transmit error strobe |
| tx_ok_i | input | 1 | Successful transmit strobe |
| rx_err_i | input | 1 | Receive error strobe |
| rx_pri_err_i | input | 1 | Primary receive error strobe |
| rx_ok_i | input | 1 | Successful receive strobe |
| bit_tick_i | input | 1 | One strobe per nominal bit |
| bit_level_i | input | 1 | Sampled bus level, 1 = recessive |
| tec_o | output | 8 | Transmit error count |
| rec_o | output | 8 | Receive error count / recovery run count |
| state_o | output | 2 | 0 active, 1 passive, 2 bus-off |
| cnt_reg_o | output | 32 | Read-only register view of both counts |

## Verification
The assertions check the following on every cycle:
- the clearing after soft reset, disable and snoop;
- zero counts on bus-off entry and a zero transmit count throughout bus-off;
- agreement between the passive state and the 128 threshold;
- a receive count that only steps by one during recovery;
- the fixed zero upper field of the register view.

Only the bench scenarios can show the following:
- the exact arithmetic: the add-8 and subtract-1 amounts, the floor at 0 and the ceiling at 255;
- the restart of a recessive run on a dominant bit;
- the fact that exactly 128 runs end recovery.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/can_fc_runcnt.sv
// Counts consecutive recessive bit strobes while bus-off recovery runs.
module can_fc_runcnt #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic tick,
  input  logic level,
  output logic run_done
);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [RW-1:0] cnt;

  // R9: a run completes on the last of RUN_LEN recessive ticks
  assign run_done = enable && tick && level && (cnt == RW'(RUN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt <= '0;
    end else if (tick) begin
      if (!level || run_done) cnt <= '0;
      else                    cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/can_fc_txcnt.sv
// Transmit error count with overflow detection toward bus-off.
module can_fc_txcnt #(
  parameter int CNT_W = 8,
  parameter int INC   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             freeze,
  input  logic             err,
  input  logic             ok,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] nxt,
  output logic             ovf
);
  localparam int SW = CNT_W + 2;
  localparam logic [SW-1:0] INC_V = SW'(INC);
  localparam logic [SW-1:0] MAX_V = SW'((1 << CNT_W) - 1);

  logic [SW-1:0] grown;

  always_comb begin
    grown = {2'b00, cnt} + (err ? INC_V : '0);
    if (ok && grown != '0) grown = grown - 1'b1;
  end

  assign nxt = grown[CNT_W-1:0];
  // R8: an update past the top of the range sends the node bus-off
  assign ovf = !freeze && (grown > MAX_V);

  always_ff @(posedge clk) begin
    if (rst || clr || ovf) cnt <= '0;
    else if (!freeze)      cnt <= nxt;
  end
endmodule

// File: rtl/can_fc_rxcnt.sv
// Receive error count; doubles as the bus-off recovery run count.
module can_fc_rxcnt #(
  parameter int CNT_W      = 8,
  parameter int PRI_INC    = 8,
  parameter int RECOV_RUNS = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             busoff,
  input  logic             err,
  input  logic             pri_err,
  input  logic             ok,
  input  logic             run_done,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] nxt,
  output logic             recov_done
);
  localparam int SW = CNT_W + 2;
  localparam logic [SW-1:0] PRI_V = SW'(PRI_INC);
  localparam logic [SW-1:0] MAX_V = SW'((1 << CNT_W) - 1);

  logic [SW-1:0] sum;

  // R6: add-1 / add-8 / subtract-1, clamped to the count range
  always_comb begin
    sum = {2'b00, cnt} + SW'(err) + (pri_err ? PRI_V : '0);
    if (ok && sum != '0) sum = sum - 1'b1;
    nxt = (sum > MAX_V) ? MAX_V[CNT_W-1:0] : sum[CNT_W-1:0];
  end

  // R10: the final recovery run ends bus-off
  assign recov_done = busoff && run_done && (cnt == CNT_W'(RECOV_RUNS - 1));

  always_ff @(posedge clk) begin
    if (rst || clr || recov_done) cnt <= '0;
    else if (busoff) begin
      if (run_done) cnt <= cnt + 1'b1;
    end else begin
      cnt <= nxt;
    end
  end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int CNT_W       = 8,
  parameter int REG_W       = 32,
  parameter int TX_INC      = 8,
  parameter int RX_PRI_INC  = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int RUN_LEN     = 11,
  parameter int RECOV_RUNS  = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst_i,
  input  logic             core_en_i,
  input  logic             snoop_i,
  input  logic             tx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_err_i,
  input  logic             rx_pri_err_i,
  input  logic             rx_ok_i,
  input  logic             bit_tick_i,
  input  logic             bit_level_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic [1:0]       state_o,
  output logic [REG_W-1:0] cnt_reg_o
);
  import can_fc_pkg::*;

  localparam int PAD_W = REG_W - 2 * CNT_W;
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(PASSIVE_LIM);

  fc_state_e        state_q;
  logic             clr_all, busoff, tx_ovf, run_done, recov_done;
  logic [CNT_W-1:0] tec_nxt, rec_nxt;

  // R1 R2 R3: soft reset, disable and snoop all clear the counts
  assign clr_all = soft_rst_i || !core_en_i || snoop_i;
  assign busoff  = (state_q == FC_BUSOFF);

  can_fc_runcnt #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst      (rst),
    .enable   (busoff && !clr_all),
    .tick     (bit_tick_i),
    .level    (bit_level_i),
    .run_done (run_done)
  );

  can_fc_txcnt #(.CNT_W(CNT_W), .INC(TX_INC)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_all || recov_done),
    .freeze (busoff),
    .err    (tx_err_i),
    .ok     (tx_ok_i),
    .cnt    (tec_o),
    .nxt    (tec_nxt),
    .ovf    (tx_ovf)
  );

  can_fc_rxcnt #(.CNT_W(CNT_W), .PRI_INC(RX_PRI_INC), .RECOV_RUNS(RECOV_RUNS)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr_all || tx_ovf),
    .busoff     (busoff),
    .err        (rx_err_i),
    .pri_err    (rx_pri_err_i),
    .ok         (rx_ok_i),
    .run_done   (run_done),
    .cnt        (rec_o),
    .nxt        (rec_nxt),
    .recov_done (recov_done)
  );

  // R7 R8 R10: fault-confinement state follows the next count values
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      state_q <= FC_ACTIVE;
    end else if (busoff) begin
      if (recov_done) state_q <= FC_ACTIVE;
    end else if (tx_ovf) begin
      state_q <= FC_BUSOFF;
    end else if (tec_nxt >= LIM_V || rec_nxt >= LIM_V) begin
      state_q <= FC_PASSIVE;
    end else begin
      state_q <= FC_ACTIVE;
    end
  end

  assign state_o = state_q;

  // R4 R3: read-only view, zero while snooping
  assign cnt_reg_o = snoop_i ? '0 : {{PAD_W{1'b0}}, rec_o, tec_o};
endmodule

// File: rtl/can_fc_chk.sv
module can_fc_chk #(
  parameter int CNT_W       = 8,
  parameter int REG_W       = 32,
  parameter int PASSIVE_LIM = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             soft_rst_i,
  input logic             core_en_i,
  input logic             snoop_i,
  input logic [CNT_W-1:0] tec_o,
  input logic [CNT_W-1:0] rec_o,
  input logic [1:0]       state_o,
  input logic [REG_W-1:0] cnt_reg_o
);
  // R1
  soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst_i |=> (tec_o == '0 && rec_o == '0 && state_o == 2'd0));

  // R2
  disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !core_en_i |=> (tec_o == '0 && rec_o == '0 && state_o == 2'd0));

  // R3
  snoop_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    snoop_i |-> cnt_reg_o == '0);

  // R4
  reg_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_reg_o[REG_W-1:2*CNT_W] == '0);

  // R7
  passive_level_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o != 2'd2) |->
      ((state_o == 2'd1) == (tec_o >= CNT_W'(PASSIVE_LIM) || rec_o >= CNT_W'(PASSIVE_LIM))));

  // R8
  busoff_entry_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2 && $past(state_o) != 2'd2) |-> (tec_o == '0 && rec_o == '0));

  // R9
  busoff_tec_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2) |-> tec_o == '0);

  // R9
  recov_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2 && $past(state_o) == 2'd2) |->
      (rec_o == $past(rec_o) || rec_o == $past(rec_o) + 1'b1));

  // R10
  no_bad_state_chk: assert property (@(posedge clk) disable iff (rst)
    state_o != 2'd3);
endmodule

bind can_fault_conf can_fc_chk #(
  .CNT_W(CNT_W), .REG_W(REG_W), .PASSIVE_LIM(PASSIVE_LIM)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .soft_rst_i (soft_rst_i),
  .core_en_i  (core_en_i),
  .snoop_i    (snoop_i),
  .tec_o      (tec_o),
  .rec_o      (rec_o),
  .state_o    (state_o),
  .cnt_reg_o  (cnt_reg_o)
);

// File: tb/tb_can_fault_conf.sv
`timescale 1ns/1ps
module tb_can_fault_conf;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic soft_rst_i = 0, core_en_i = 0, snoop_i = 0;
  logic tx_err_i = 0, tx_ok_i = 0, rx_err_i = 0, rx_pri_err_i = 0, rx_ok_i = 0;
  logic bit_tick_i = 0, bit_level_i = 1;
  logic [7:0]  tec_o, rec_o;
  logic [1:0]  state_o;
  logic [31:0] cnt_reg_o;

  always #2 clk = ~clk;

  can_fault_conf dut (
    .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i), .core_en_i(core_en_i),
    .snoop_i(snoop_i), .tx_err_i(tx_err_i), .tx_ok_i(tx_ok_i),
    .rx_err_i(rx_err_i), .rx_pri_err_i(rx_pri_err_i), .rx_ok_i(rx_ok_i),
    .bit_tick_i(bit_tick_i), .bit_level_i(bit_level_i),
    .tec_o(tec_o), .rec_o(rec_o), .state_o(state_o), .cnt_reg_o(cnt_reg_o)
  );

  typedef struct {
    int          tec;
    int          rec;
    int          st;
    logic [31:0] rg;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int    checks = 0, errors = 0;
  bit    done = 0;

  // reference model state
  int m_tec = 0, m_rec = 0, m_st = 0, m_run = 0;

  task automatic step(input bit s, input bit en, input bit sn,
                      input bit txe, input bit txo, input bit rxe,
                      input bit rxp, input bit rxo, input bit tk,
                      input bit lv, input string tag);
    exp_t e;
    int t, r;
    @(negedge clk);
    soft_rst_i = s; core_en_i = en; snoop_i = sn;
    tx_err_i = txe; tx_ok_i = txo; rx_err_i = rxe; rx_pri_err_i = rxp;
    rx_ok_i = rxo; bit_tick_i = tk; bit_level_i = lv;
    if (s || !en || sn) begin
      m_tec = 0; m_rec = 0; m_st = 0; m_run = 0;
    end else if (m_st == 2) begin
      if (tk) begin
        if (!lv) m_run = 0;
        else if (m_run == 10) begin
          m_run = 0;
          if (m_rec == 127) begin m_st = 0; m_tec = 0; m_rec = 0; end
          else m_rec = m_rec + 1;
        end else m_run = m_run + 1;
      end
    end else begin
      t = m_tec + (txe ? 8 : 0) - (txo ? 1 : 0);
      if (t < 0) t = 0;
      r = m_rec + (rxe ? 1 : 0) + (rxp ? 8 : 0) - (rxo ? 1 : 0);
      if (r < 0) r = 0;
      if (r > 255) r = 255;
      if (t > 255) begin
        m_st = 2; m_tec = 0; m_rec = 0; m_run = 0;
      end else begin
        m_tec = t; m_rec = r;
        m_st = (t >= 128 || r >= 128) ? 1 : 0;
      end
    end
    e.tec = m_tec; e.rec = m_rec; e.st = m_st;
    e.rg = sn ? 32'h0 : {16'h0, m_rec[7:0], m_tec[7:0]};
    q.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic txe(input string tag);
    step(0, 1, 0, 1, 0, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic txo(input string tag);
    step(0, 1, 0, 0, 1, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic rxp(input string tag);
    step(0, 1, 0, 0, 0, 0, 1, 0, 0, 1, tag);
  endtask
  task automatic rxo(input string tag);
    step(0, 1, 0, 0, 0, 0, 0, 1, 0, 1, tag);
  endtask
  task automatic bit_in(input bit lv, input string tag);
    step(0, 1, 0, 0, 0, 0, 0, 0, 1, lv, tag);
  endtask

  // monitor: compare one expected item after each edge that follows a push
  always @(posedge clk) begin
    exp_t  e;
    string tg;
    #1;
    if (q.size() > 0) begin
      e  = q.pop_front();
      tg = tq.pop_front();
      checks++;
      if (tec_o !== e.tec[7:0] || rec_o !== e.rec[7:0] ||
          state_o !== e.st[1:0] || cnt_reg_o !== e.rg) begin
        errors++;
        $display("FAIL %s tec=%0d rec=%0d st=%0d reg=%h expected tec=%0d rec=%0d st=%0d reg=%h",
                 tg, tec_o, rec_o, state_o, cnt_reg_o, e.tec, e.rec, e.st, e.rg);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle("R1 reset state");
    // R5 transmit arithmetic
    repeat (3) txe("R5 tx err +8");
    txo("R5 tx ok -1");
    // R6 receive arithmetic
    step(0, 1, 0, 0, 0, 1, 0, 0, 0, 1, "R6 rx err +1");
    rxp("R6 rx primary +8");
    rxo("R6 rx ok -1");
    step(0, 1, 0, 0, 0, 1, 1, 1, 0, 1, "R6 combined rx strobes");
    idle("R4 register layout");
    // R1 soft reset
    step(1, 1, 0, 1, 0, 0, 0, 0, 0, 1, "R1 soft reset clears");
    txo("R5 tx floor at 0");
    rxo("R6 rx floor at 0");
    // R2 disable
    txe("R2 setup");
    step(0, 0, 0, 1, 0, 1, 1, 0, 0, 1, "R2 disable clears");
    step(0, 0, 0, 1, 0, 0, 1, 0, 0, 1, "R2 strobes ignored when disabled");
    // R3 snoop
    txe("R3 setup");
    rxp("R3 setup");
    step(0, 1, 1, 1, 0, 1, 1, 0, 0, 1, "R3 snoop clears");
    step(0, 1, 1, 1, 0, 0, 1, 0, 0, 1, "R3 snoop holds zero");
    idle("R3 leave snoop");
    // R7 passive by transmit count
    for (int i = 0; i < 16; i++) txe("R7 tx toward passive");
    txo("R7 tx back to active");
    txe("R7 tx passive again");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R1 clear");
    // R7 passive by receive count, R6 ceiling
    for (int i = 0; i < 16; i++) rxp("R7 rx toward passive");
    rxo("R7 rx back to active");
    for (int i = 0; i < 20; i++) rxp("R6 rx ceiling 255");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R1 clear");
    // R8 bus-off entry
    rxp("R8 setup rx");
    for (int i = 0; i < 32; i++) txe("R8 tx toward bus-off");
    // R9 bus-off behaviour
    step(0, 1, 0, 1, 1, 1, 1, 1, 0, 1, "R9 strobes ignored in bus-off");
    for (int i = 0; i < 10; i++) bit_in(1, "R9 recessive run");
    bit_in(0, "R9 dominant restarts run");
    for (int i = 0; i < 10; i++) bit_in(1, "R9 recessive run");
    idle("R9 gap without tick");
    bit_in(1, "R9 run complete rec=1");
    // R10 remaining runs
    for (int r = 0; r < 127; r++)
      for (int b = 0; b < 11; b++) bit_in(1, "R10 recovery run");
    idle("R10 back to active");
    txe("R10 counting resumes");
    // R1 soft reset inside bus-off
    for (int i = 0; i < 32; i++) txe("R8 tx toward bus-off");
    bit_in(1, "R9 recovery start");
    step(1, 1, 0, 0, 0, 0, 0, 0, 1, 1, "R1 soft reset leaves bus-off");
    idle("R1 after soft reset");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule